// File: doc/BRIEF.md
# ChaCha20 Keystream Engine

This block turns a 256-bit key, a 96-bit nonce and a 32-bit block counter into 512-bit blocks of ChaCha20 keystream and combines each block with one 512-bit data word. Software first issues a load command that captures key, nonce and a starting counter. After that, every data word handed over on the valid/ready input port comes back on the output port XORed with the keystream for the current counter. The counter then steps forward by one, so no counter value is used twice under one key. Encryption and decryption are the same operation: feeding ciphertext back in under the same key, nonce and counter returns the plaintext.

The working state is a 4x4 matrix of 32-bit words. One round, made of four quarter-rounds using only 32-bit addition, fixed rotations and XOR, is applied per clock. Twenty rounds are applied, and then the starting matrix is added back word by word. If the counter would wrap past its last value, the engine raises a sticky error and takes no more data until the next load. A load at any time also abandons a block that is in flight or waiting to be collected.

Top module: `chacha_ks_engine`

## Requirements
- R1: After reset, and until the first load, in_ready, out_valid and ctr_err are all 0, and data offered on in_valid is not taken.
- R2: The starting matrix holds these words. Word 0 is 0x61707865, word 1 is 0x3320646e, word 2 is 0x79622d32 and word 3 is 0x6b206574. Words 4 to 11 are key[32i+31:32i] for i = 0..7. Word 12 is the block counter. Words 13 to 15 are nonce[31:0], nonce[63:32] and nonce[95:64]. Byte k of each 32-bit word stream sits at bits [8k+7:8k] (little-endian).
- R3: Twenty rounds are applied. Even rounds work on the columns (0,4,8,12) to (3,7,11,15). Odd rounds work on the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). Each quarter-round uses rotations of 16, 12, 8 and 7. After the rounds the starting matrix is added word-wise modulo 2^32. Keystream word i sits at out bits [32i+31:32i].
- R4: out_data is the keystream XORed with the accepted in_data, so running a result through again under the same key, nonce and counter gives the original data back.
- R5: out_valid rises exactly 20 clock edges after the edge that accepts a word. in_ready stays 0 from that accepting edge until the result has been taken.
- R6: While out_valid is 1 and out_ready is 0, out_valid and out_data hold their values.
- R7: Each completed block advances the counter by one, so successive words use consecutive counter values.
- R8: A block that uses counter 0xFFFFFFFF is still produced. ctr_err is then set and in_ready stays 0, and ctr_err stays set until a load.
- R9: A load captures key, nonce and ctr_start, clears ctr_err, and discards any block in progress or waiting on the output. out_valid is 0 on the following cycle and no stale result appears later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture key, nonce and starting counter; re-initialise |
| key | input | 256 | Cipher key, little-endian words |
| nonce | input | 96 | Nonce, little-endian words |
| ctr_start | input | 32 | Counter value for the first block after a load |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Engine can take a data word |
| in_data | input | 512 | Data word to encrypt or decrypt |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result collected this cycle |
| out_data | output | 512 | Data XOR keystream |
| ctr_err | output | 1 | Counter exhausted; sticky until load |

## Verification
A word is taken on the edge where in_valid and in_ready are both high. Its result is due exactly 20 edges later, and the bench counts falling edges from the one after the accepting edge, so the count must equal 20 when out_valid is first seen. The effects of a load or of the final block on ctr_err, in_ready and out_valid are due one edge later, and the bench looks for them at the next falling edge. Every input is driven and every output sampled on falling edges, so each check sees settled values from the preceding rising edge.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 16;
  localparam int BLOCK_W = WORD_W * NWORDS;
  localparam int KEY_W   = 256;
  localparam int NONCE_W = 96;
  localparam int CTR_W   = 32;
  localparam int KEY_WORDS   = KEY_W / WORD_W;
  localparam int NONCE_WORDS = NONCE_W / WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NWORDS-1:0][WORD_W-1:0] state_t;
  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  typedef enum logic [1:0] {
    SQ_NOKEY = 2'd0,
    SQ_IDLE  = 2'd1,
    SQ_RUN   = 2'd2,
    SQ_HOLD  = 2'd3
  } seq_state_t;

  function automatic word_t sigma_word(input int idx);
    case (idx)
      0:       return 32'h61707865;
      1:       return 32'h3320646e;
      2:       return 32'h79622d32;
      default: return 32'h6b206574;
    endcase
  endfunction

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic quad_t quarter(input quad_t q);
    quad_t r;
    r = q;
    r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 16);
    r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 12);
    r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 8);
    r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 7);
    return r;
  endfunction

  function automatic state_t init_state(input logic [KEY_W-1:0] k,
                                        input logic [NONCE_W-1:0] n,
                                        input logic [CTR_W-1:0] c);
    state_t s;
    for (int i = 0; i < 4; i++) s[i] = sigma_word(i);
    for (int i = 0; i < KEY_WORDS; i++) s[4+i] = k[WORD_W*i +: WORD_W];
    s[12] = c;
    for (int i = 0; i < NONCE_WORDS; i++) s[13+i] = n[WORD_W*i +: WORD_W];
    return s;
  endfunction

  function automatic state_t feed_forward(input state_t x, input state_t y);
    state_t s;
    for (int i = 0; i < NWORDS; i++) s[i] = x[i] + y[i];
    return s;
  endfunction
endpackage

// File: rtl/chacha_round.sv
module chacha_round
  import chacha_pkg::*;
(
  input  state_t s_in,
  input  logic   diag,
  output state_t s_out
);
  quad_t q_in  [4];
  quad_t q_out [4];

  for (genvar q = 0; q < 4; q++) begin : g_qr
    // column: (q, 4+q, 8+q, 12+q); diagonal: (q, 4+(q+1)%4, 8+(q+2)%4, 12+(q+3)%4)
    assign q_in[q].a = s_in[q];
    assign q_in[q].b = diag ? s_in[4  + ((q+1)%4)] : s_in[4+q];
    assign q_in[q].c = diag ? s_in[8  + ((q+2)%4)] : s_in[8+q];
    assign q_in[q].d = diag ? s_in[12 + ((q+3)%4)] : s_in[12+q];
    assign q_out[q]  = quarter(q_in[q]);
    // write results back to the positions each quarter-round read from
    assign s_out[q]    = q_out[q].a;
    assign s_out[4+q]  = diag ? q_out[(q+3)%4].b : q_out[q].b;
    assign s_out[8+q]  = diag ? q_out[(q+2)%4].c : q_out[q].c;
    assign s_out[12+q] = diag ? q_out[(q+1)%4].d : q_out[q].d;
  end
endmodule

// File: rtl/chacha_seq.sv
module chacha_seq
  import chacha_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CTR_W-1:0] ctr_start,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             running,
  output logic             diag,
  output logic             last_round,
  output logic [CTR_W-1:0] ctr,
  output logic             ctr_err
);
  localparam int RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(ROUNDS - 1);

  seq_state_t       st;
  logic [RND_W-1:0] rnd;

  assign in_ready   = (st == SQ_IDLE) && !ctr_err;
  assign out_valid  = (st == SQ_HOLD);
  assign running    = (st == SQ_RUN);
  assign diag       = rnd[0];
  assign last_round = running && (rnd == RND_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_NOKEY;
      rnd     <= '0;
      ctr     <= '0;
      ctr_err <= 1'b0;
    end else if (load) begin
      st      <= SQ_IDLE;
      rnd     <= '0;
      ctr     <= ctr_start;
      ctr_err <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (in_valid && in_ready) begin
          st  <= SQ_RUN;
          rnd <= '0;
        end
        SQ_RUN: if (last_round) begin
          st  <= SQ_HOLD;
          ctr <= ctr + 1'b1;
          if (ctr == {CTR_W{1'b1}}) ctr_err <= 1'b1;
        end else begin
          rnd <= rnd + 1'b1;
        end
        SQ_HOLD: if (out_ready) st <= SQ_IDLE;
        default: st <= SQ_NOKEY;
      endcase
    end
  end
endmodule

// File: rtl/chacha_ks_engine.sv
module chacha_ks_engine
  import chacha_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [KEY_W-1:0]   key,
  input  logic [NONCE_W-1:0] nonce,
  input  logic [CTR_W-1:0]   ctr_start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BLOCK_W-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BLOCK_W-1:0] out_data,
  output logic               ctr_err
);
  logic [KEY_W-1:0]   key_q;
  logic [NONCE_W-1:0] nonce_q;
  logic [CTR_W-1:0]   ctr;
  logic               running, diag, last_round;
  state_t             work_q, round_out, init_now, ks_block;
  logic [BLOCK_W-1:0] data_q, out_q;

  // named events for the checker
  logic accept, finish;
  assign accept = in_valid && in_ready;
  assign finish = last_round;

  chacha_seq #(.ROUNDS(ROUNDS)) seq_i (
    .clk(clk), .rst_n(rst_n), .load(load), .ctr_start(ctr_start),
    .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .running(running),
    .diag(diag), .last_round(last_round), .ctr(ctr), .ctr_err(ctr_err)
  );

  chacha_round round_i (.s_in(work_q), .diag(diag), .s_out(round_out));

  // starting matrix is rebuilt from the held key/nonce/counter, not stored
  assign init_now = init_state(key_q, nonce_q, ctr);
  assign ks_block = feed_forward(round_out, init_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      nonce_q <= '0;
    end else if (load) begin
      key_q   <= key;
      nonce_q <= nonce;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      data_q <= '0;
      out_q  <= '0;
    end else if (!load) begin
      if (accept) begin
        work_q <= init_now;
        data_q <= in_data;
      end else if (running) begin
        work_q <= round_out;
      end
      if (finish) out_q <= ks_block ^ data_q;
    end
  end

  assign out_data = out_q;
endmodule

// File: rtl/chacha_ks_checker.sv
module chacha_ks_checker
  import chacha_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [BLOCK_W-1:0] out_data,
  input logic               ctr_err,
  input logic               accept,
  input logic               finish
);
  logic [15:0] lat_cnt;
  logic        pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      pending <= 1'b0;
    end else if (load) begin
      lat_cnt <= '0;
      pending <= 1'b0;
    end else if (accept) begin
      lat_cnt <= '0;
      pending <= 1'b1;
    end else if (pending && !out_valid) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (pending && lat_cnt == 16'(ROUNDS)));
  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !load) |=> !in_ready);
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  assert_finish_gives_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !load) |=> out_valid);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_err && !load) |=> ctr_err);
  assert_err_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_err |-> !in_ready);
  assert_load_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!ctr_err && !out_valid));
endmodule

bind chacha_ks_engine chacha_ks_checker #(.ROUNDS(ROUNDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .load(load), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .ctr_err(ctr_err), .accept(accept), .finish(finish)
);

// File: tb/chacha_ks_engine_tb.sv
`timescale 1ns/1ps
module chacha_ks_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [255:0] key = '0;
  logic [95:0]  nonce = '0;
  logic [31:0]  ctr_start = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [511:0] out_data;
  logic         ctr_err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  chacha_ks_engine dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .key(key), .nonce(nonce),
    .ctr_start(ctr_start), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .ctr_err(ctr_err)
  );

  // ---------------- reference model (own formulation) ----------------
  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [127:0] qr_ref(input logic [31:0] a, b, c, d);
    a += b; d = rl(d ^ a, 16);
    c += d; b = rl(b ^ c, 12);
    a += b; d = rl(d ^ a, 8);
    c += d; b = rl(b ^ c, 7);
    return {a, b, c, d};
  endfunction

  function automatic logic [511:0] ref_ks(input logic [255:0] k,
                                          input logic [95:0] n,
                                          input logic [31:0] c);
    logic [31:0] x [16];
    logic [31:0] y [16];
    logic [127:0] r;
    logic [511:0] o;
    x[0] = 32'h61707865; x[1] = 32'h3320646e;
    x[2] = 32'h79622d32; x[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) x[4+i] = k[32*i +: 32];
    x[12] = c;
    for (int i = 0; i < 3; i++) x[13+i] = n[32*i +: 32];
    for (int i = 0; i < 16; i++) y[i] = x[i];
    for (int rd = 0; rd < 20; rd++) begin
      for (int q = 0; q < 4; q++) begin
        int sh;
        int ia, ib, ic, id;
        sh = rd % 2;
        ia = q;
        ib = 4 + ((q + sh) % 4);
        ic = 8 + ((q + 2*sh) % 4);
        id = 12 + ((q + 3*sh) % 4);
        r = qr_ref(y[ia], y[ib], y[ic], y[id]);
        y[ia] = r[127:96]; y[ib] = r[95:64]; y[ic] = r[63:32]; y[id] = r[31:0];
      end
    end
    for (int i = 0; i < 16; i++) o[32*i +: 32] = y[i] + x[i];
    return o;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req,
                       input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [255:0] k, input logic [95:0] n,
                         input logic [31:0] c);
    load = 1'b1; key = k; nonce = n; ctr_start = c;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic start_block(input logic [511:0] d);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(output int lat, output bit busy_ok);
    lat = 0; busy_ok = 1'b1;
    while (!out_valid) begin
      if (in_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic take;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_block(input logic [511:0] d, output logic [511:0] r);
    int  lat;
    bit  bz;
    start_block(d);
    wait_out(lat, bz);
    r = out_data;
    take();
  endtask

  function automatic logic [511:0] pattern(input int s);
    logic [511:0] p;
    for (int i = 0; i < 16; i++) p[32*i +: 32] = 32'h9e3779b9 * (s * 16 + i + 1);
    return p;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [255:0] k0;
    logic [95:0]  n0;
    logic [511:0] r, exp, ct;
    int  lat;
    bit  bz, seen;

    for (int i = 0; i < 32; i++) k0[8*i +: 8] = 8'(i);
    n0 = 96'h0000_0000_4a00_0000_0900_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, nothing taken before a load
    check(in_ready == 1'b0, "R1 in_ready", 512'(in_ready), 512'(0));
    check(out_valid == 1'b0, "R1 out_valid", 512'(out_valid), 512'(0));
    check(ctr_err == 1'b0, "R1 ctr_err", 512'(ctr_err), 512'(0));
    in_valid = 1'b1; seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (in_ready || out_valid) seen = 1'b1;
    end
    in_valid = 1'b0;
    check(!seen, "R1 no acceptance before load", 512'(seen), 512'(0));

    // R3: quarter-round published vector (bench model sanity)
    check(qr_ref(32'h11111111, 32'h01020304, 32'h9b8d6f43, 32'h01234567)
          == 128'hea2a92f4_cb1cf8ce_4581472e_5881c4bb,
          "R3 quarter-round vector",
          512'(qr_ref(32'h11111111, 32'h01020304, 32'h9b8d6f43, 32'h01234567)),
          512'(128'hea2a92f4_cb1cf8ce_4581472e_5881c4bb));

    // R2/R3/R5: published block vector, latency and busy
    do_load(k0, n0, 32'd1);
    start_block('0);
    wait_out(lat, bz);
    check(lat == 20, "R5 latency", 512'(lat), 512'(20));
    check(bz, "R5 in_ready low while busy", 512'(bz), 512'(1));
    check(out_data[31:0] == 32'he4e7f110, "R3 published word0",
          512'(out_data[31:0]), 512'(32'he4e7f110));
    check(out_data[511:480] == 32'h4e3c50a2, "R3 published word15",
          512'(out_data[511:480]), 512'(32'h4e3c50a2));
    exp = ref_ks(k0, n0, 32'd1);
    check(out_data == exp, "R2 R3 full block", out_data, exp);

    // R6: hold while out_ready low
    r = out_data; seen = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!out_valid || out_data != r) seen = 1'b1;
    end
    check(!seen, "R6 hold", 512'(seen), 512'(0));
    take();
    check(out_valid == 1'b0, "R6 released after take", 512'(out_valid), 512'(0));

    // R7/R4: next counter value with data
    run_block(pattern(1), r);
    exp = ref_ks(k0, n0, 32'd2) ^ pattern(1);
    check(r == exp, "R7 R4 counter 2 with data", r, exp);

    // R4: symmetry by reloading and feeding the ciphertext back
    do_load(k0, n0, 32'd5);
    run_block(pattern(2), ct);
    do_load(k0, n0, 32'd5);
    run_block(ct, r);
    check(r == pattern(2), "R4 decrypt restores data", r, pattern(2));

    // R2/R7: sweep of keys, nonces and counters
    for (int t = 0; t < 6; t++) begin
      logic [255:0] k;
      logic [95:0]  n;
      logic [31:0]  c;
      for (int i = 0; i < 8; i++) k[32*i +: 32] = 32'h01000193 * (t * 8 + i + 3);
      n = {32'(t) * 32'h01010101, 32'h80000000 >> t, 32'(1 << (t * 5))};
      c = 32'h10000 * t + 32'(t);
      do_load(k, n, c);
      for (int b = 0; b < 3; b++) begin
        run_block(pattern(t * 3 + b), r);
        exp = ref_ks(k, n, c + 32'(b)) ^ pattern(t * 3 + b);
        check(r == exp, "R2 R7 sweep block", r, exp);
      end
    end

    // R8: counter wrap
    do_load(k0, n0, 32'hFFFF_FFFE);
    run_block(pattern(40), r);
    exp = ref_ks(k0, n0, 32'hFFFF_FFFE) ^ pattern(40);
    check(r == exp, "R8 block at FFFFFFFE", r, exp);
    check(ctr_err == 1'b0, "R8 no error before last", 512'(ctr_err), 512'(0));
    run_block(pattern(41), r);
    exp = ref_ks(k0, n0, 32'hFFFF_FFFF) ^ pattern(41);
    check(r == exp, "R8 block at FFFFFFFF produced", r, exp);
    check(ctr_err == 1'b1, "R8 error raised", 512'(ctr_err), 512'(1));
    in_valid = 1'b1; seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (in_ready || out_valid || !ctr_err) seen = 1'b1;
    end
    in_valid = 1'b0;
    check(!seen, "R8 refuses data, sticky", 512'(seen), 512'(0));

    // R9: load clears error and restarts counter
    do_load(k0, n0, 32'd0);
    check(ctr_err == 1'b0, "R9 load clears error", 512'(ctr_err), 512'(0));
    run_block(pattern(42), r);
    exp = ref_ks(k0, n0, 32'd0) ^ pattern(42);
    check(r == exp, "R9 block after reload", r, exp);

    // R9: load during a running block discards it
    start_block(pattern(43));
    repeat (5) @(negedge clk);
    do_load(~k0, n0, 32'd77);
    seen = 1'b0;
    for (int i = 0; i < 25; i++) begin
      if (out_valid) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R9 running block discarded", 512'(seen), 512'(0));
    run_block(pattern(44), r);
    exp = ref_ks(~k0, n0, 32'd77) ^ pattern(44);
    check(r == exp, "R9 new parameters used", r, exp);

    // R9: load while a result waits
    start_block(pattern(45));
    wait_out(lat, bz);
    do_load(k0, ~n0, 32'd9);
    check(out_valid == 1'b0, "R9 pending result dropped", 512'(out_valid), 512'(0));
    run_block(pattern(46), r);
    exp = ref_ks(k0, ~n0, 32'd9) ^ pattern(46);
    check(r == exp, "R9 block after drop", r, exp);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule